// File: doc/BRIEF.md
# Monitor-Wait Address Watch Unit

This unit lets a core sleep until another agent writes a memory line it has chosen to watch. Software first issues an arm command carrying a virtual address. It then issues a wait command carrying the already translated physical address. The unit keeps the cache-line-aligned form of that physical address. While armed and waiting, it compares every incoming coherence snoop against that line. A matching snoop, or a generic wakeup input, ends the sleep.

A pending-wakeup flag records every wakeup event. If a wakeup arrives between the arm and the wait, the following wait sees the flag, consumes it and reports that the core did not halt, so no wakeup is lost. The halt request to the core stays high from a halting wait until the cycle after the wakeup pulse.

At arm time the unit also reports the byte span of the watched access. The span is trimmed so that the access never crosses into the next line.

All outputs are registered. Each reacts one clock after the input that causes it.

Top module: `monitor_wait_watch`

## Requirements
- R1: After reset, `armed`, `halt_req`, `wake_pulse`, `wait_done` and `wait_halted` are 0, and no wakeup is pending.
- R2: An arm command sets `armed` and loads `mon_vaddr` with the arm address. `mon_span` becomes LINE_BYTES minus the address offset within the line, or LINE_BYTES when that offset is 0. The stored watched line is reset to physical address 0.
- R3: A wait command with no wakeup pending makes the unit store the wait address with its low log2(LINE_BYTES) bits cleared and start waiting. The next cycle shows `wait_done`=1, `wait_halted`=1 and `halt_req`=1.
- R4: A wait command with a wakeup pending, or with `wake_in` high in the same cycle, gives `wait_done`=1 and `wait_halted`=0 one cycle later. It clears the pending flag, leaves the unit not waiting and leaves `halt_req` low. The next wait then halts.
- R5: A valid snoop wakes the core only while the unit is armed and waiting, and only if its address with the low log2(LINE_BYTES) bits cleared equals the stored line. Any byte address inside the line matches, and an address in a different line does not. On a match, `wake_pulse` is 1 for exactly the next cycle and waiting ends.
- R6: `halt_req` stays 1 through the `wake_pulse` cycle and is 0 in the cycle after it, unless a new halting wait is issued.
- R7: Every wakeup event sets the pending flag, whether it comes from a matching snoop or from `wake_in`. A wait issued after a snoop wakeup therefore reports `wait_halted`=0.
- R8: When an arm command and a matching snoop fall in the same cycle, the arm takes effect and the snoop produces no `wake_pulse`.
- R9: A snoop with `snoop_valid` low never produces a match.
- R10: `wake_in` while waiting ends the wait and gives `wake_pulse`=1 one cycle later. `wake_in` while not waiting gives no pulse and only sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm command strobe |
| arm_vaddr | input | VA_W | Virtual address to monitor |
| wait_valid | input | 1 | Wait command strobe |
| wait_paddr | input | PA_W | Translated physical address of the monitored access |
| snoop_valid | input | 1 | Snoop address valid |
| snoop_addr | input | PA_W | Snooped physical address |
| wake_in | input | 1 | Generic wakeup event |
| halt_req | output | 1 | Request that the core stays halted |
| wake_pulse | output | 1 | One-cycle wakeup indication |
| wait_done | output | 1 | A wait command completed (result valid) |
| wait_halted | output | 1 | The completed wait halted the core |
| armed | output | 1 | Monitor is armed |
| mon_vaddr | output | VA_W | Armed virtual address |
| mon_span | output | log2(LINE_BYTES)+1 | Bytes watched, trimmed at the first line boundary |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a wait command and a wakeup. The bench drives `wait_valid` and `wake_in` on the same clock edge. It expects the wait to treat the wakeup as having arrived first and to report no halt. It then confirms that a further wait does halt, which shows the pending flag was consumed.

The second pair is an arm command and a matching snoop. The bench drives both on the same edge while the unit is waiting. It judges this by the absence of `wake_pulse`, followed by a wake from a snoop to line 0, which confirms that the arm cleared the stored line.

// File: rtl/monitor_wait_watch.sv
module monitor_wait_watch #(
  parameter int PA_W       = 48,
  parameter int VA_W       = 48,
  parameter int LINE_BYTES = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            arm_valid,
  input  logic [VA_W-1:0]                 arm_vaddr,
  input  logic                            wait_valid,
  input  logic [PA_W-1:0]                 wait_paddr,
  input  logic                            snoop_valid,
  input  logic [PA_W-1:0]                 snoop_addr,
  input  logic                            wake_in,
  output logic                            halt_req,
  output logic                            wake_pulse,
  output logic                            wait_done,
  output logic                            wait_halted,
  output logic                            armed,
  output logic [VA_W-1:0]                 mon_vaddr,
  output logic [$clog2(LINE_BYTES):0]     mon_span
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SPAN_W = OFF_W + 1;
  localparam logic [PA_W-1:0] LINE_MASK = {PA_W{1'b1}} << OFF_W;
  localparam logic [SPAN_W-1:0] FULL_SPAN = SPAN_W'(LINE_BYTES);

  logic              armed_q, waiting_q, pend_q;
  logic [PA_W-1:0]   line_q;
  logic              halt_q, wake_q, done_q, halted_q;
  logic [VA_W-1:0]   vaddr_q;
  logic [SPAN_W-1:0] span_q;

  logic [OFF_W-1:0]  arm_off;
  logic [SPAN_W-1:0] span_d;
  logic              snoop_hit, wake_evt, eff_pend, halting_wait;

  assign arm_off = arm_vaddr[OFF_W-1:0];
  assign span_d  = (arm_off == '0) ? FULL_SPAN : FULL_SPAN - {1'b0, arm_off};

  assign snoop_hit    = snoop_valid && armed_q && waiting_q && !arm_valid &&
                        ((snoop_addr & LINE_MASK) == line_q);
  assign wake_evt     = snoop_hit || wake_in;
  assign eff_pend     = pend_q || wake_evt;
  assign halting_wait = wait_valid && !eff_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      waiting_q <= 1'b0;
      pend_q    <= 1'b0;
      line_q    <= '0;
      vaddr_q   <= '0;
      span_q    <= '0;
      halt_q    <= 1'b0;
      wake_q    <= 1'b0;
      done_q    <= 1'b0;
      halted_q  <= 1'b0;
    end else begin
      if (arm_valid) begin
        armed_q <= 1'b1;
        vaddr_q <= arm_vaddr;
        span_q  <= span_d;
      end

      if (wait_valid && !eff_pend) line_q <= wait_paddr & LINE_MASK;
      else if (arm_valid)          line_q <= '0;

      if (wait_valid)       pend_q <= 1'b0;
      else if (wake_evt)    pend_q <= 1'b1;

      if (halting_wait)     waiting_q <= 1'b1;
      else if (wake_evt)    waiting_q <= 1'b0;

      wake_q   <= waiting_q && wake_evt;
      done_q   <= wait_valid;
      halted_q <= halting_wait;

      if (halting_wait)     halt_q <= 1'b1;
      else if (wake_q)      halt_q <= 1'b0;
    end
  end

  assign halt_req    = halt_q;
  assign wake_pulse  = wake_q;
  assign wait_done   = done_q;
  assign wait_halted = halted_q;
  assign armed       = armed_q;
  assign mon_vaddr   = vaddr_q;
  assign mon_span    = span_q;
endmodule

// File: rtl/monitor_wait_watch_checker.sv
module monitor_wait_watch_checker #(
  parameter int LINE_BYTES = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        arm_valid,
  input logic                        wait_valid,
  input logic                        snoop_valid,
  input logic                        wake_in,
  input logic                        halt_req,
  input logic                        wake_pulse,
  input logic                        wait_done,
  input logic                        wait_halted,
  input logic                        armed,
  input logic [$clog2(LINE_BYTES):0] mon_span
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!halt_req && !wake_pulse && !armed && !wait_done));

  a_r2_span_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> (mon_span != '0 && mon_span <= ($clog2(LINE_BYTES)+1)'(LINE_BYTES)));

  a_r3_halted_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    wait_halted |-> (wait_done && halt_req));

  a_r6_pulse_under_halt: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> halt_req);

  a_r6_halt_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && !wait_valid) |=> !halt_req);

  a_r8_arm_masks_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_valid && !wake_in) |=> !wake_pulse);

  a_r9_idle_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!snoop_valid && !wake_in) |=> !wake_pulse);

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && !wait_valid) |=> !wake_pulse);
endmodule

bind monitor_wait_watch monitor_wait_watch_checker #(.LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/test_monitor_wait_watch.sv
module test_monitor_wait_watch;
  localparam int PA_W = 48;
  localparam int VA_W = 48;
  localparam int LB   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_valid = 1'b0, wait_valid = 1'b0, snoop_valid = 1'b0, wake_in = 1'b0;
  logic [VA_W-1:0] arm_vaddr = '0;
  logic [PA_W-1:0] wait_paddr = '0, snoop_addr = '0;
  logic halt_req, wake_pulse, wait_done, wait_halted, armed;
  logic [VA_W-1:0] mon_vaddr;
  logic [6:0] mon_span;

  int checks = 0;
  int failures = 0;
  bit exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  monitor_wait_watch #(.PA_W(PA_W), .VA_W(VA_W), .LINE_BYTES(LB)) i_monitor_wait_watch (
    .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_vaddr(arm_vaddr),
    .wait_valid(wait_valid), .wait_paddr(wait_paddr), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .wake_in(wake_in), .halt_req(halt_req),
    .wake_pulse(wake_pulse), .wait_done(wait_done), .wait_halted(wait_halted),
    .armed(armed), .mon_vaddr(mon_vaddr), .mon_span(mon_span));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected halt result per completed wait.
  always @(negedge clk) begin
    if (rst_n && wait_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R3/R4 unexpected wait result", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk(wait_halted == e, r, wait_halted, e);
      end
    end
  end

  task automatic idle();
    arm_valid = 0; wait_valid = 0; snoop_valid = 0; wake_in = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_arm(input logic [VA_W-1:0] va);
    arm_valid = 1; arm_vaddr = va;
    tick();
  endtask

  task automatic do_wait(input logic [PA_W-1:0] pa, input bit exp_halt, input string r);
    wait_valid = 1; wait_paddr = pa;
    exp_q.push_back(exp_halt); req_q.push_back(r);
    tick();
  endtask

  task automatic do_snoop(input bit v, input logic [PA_W-1:0] a);
    snoop_valid = v; snoop_addr = a;
    tick();
  endtask

  task automatic do_wake();
    wake_in = 1;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(halt_req == 0 && wake_pulse == 0 && armed == 0 && wait_done == 0, "R1 reset outputs",
        {halt_req, wake_pulse, armed, wait_done}, 0);
    rst_n = 1;
    @(negedge clk);

    do_arm(48'h1000);
    chk(armed == 1, "R2 armed", armed, 1);
    chk(mon_vaddr == 48'h1000, "R2 vaddr", mon_vaddr, 48'h1000);
    chk(mon_span == 7'd64, "R2 aligned span", mon_span, 64);
    do_arm(48'h1030);
    chk(mon_span == 7'd16, "R2 trimmed span", mon_span, 16);
    do_arm(48'h1008);
    chk(mon_span == 7'd56, "R2 trimmed span", mon_span, 56);

    do_wait(48'h2_0008, 1'b1, "R3 halting wait");
    chk(halt_req == 1, "R3 halt_req", halt_req, 1);

    do_snoop(1'b1, 48'h3_0000);
    chk(wake_pulse == 0 && halt_req == 1, "R5 other line ignored", wake_pulse, 0);
    do_snoop(1'b0, 48'h2_0000);
    chk(wake_pulse == 0 && halt_req == 1, "R9 invalid snoop ignored", wake_pulse, 0);

    do_snoop(1'b1, 48'h2_003F);
    chk(wake_pulse == 1, "R5 in-line byte wakes", wake_pulse, 1);
    chk(halt_req == 1, "R6 halt held in pulse cycle", halt_req, 1);
    tick();
    chk(wake_pulse == 0, "R5 single pulse", wake_pulse, 0);
    chk(halt_req == 0, "R6 halt dropped after pulse", halt_req, 0);

    do_wait(48'h2_0000, 1'b0, "R7 snoop wake left pending");
    chk(halt_req == 0, "R4 no halt when pending", halt_req, 0);
    do_wait(48'h2_0000, 1'b1, "R4 pending consumed");

    arm_valid = 1; arm_vaddr = 48'h4000; snoop_valid = 1; snoop_addr = 48'h2_0000;
    tick();
    chk(wake_pulse == 0 && halt_req == 1, "R8 arm beats snoop", wake_pulse, 0);
    do_snoop(1'b1, 48'h10);
    chk(wake_pulse == 1, "R2 line cleared to zero by arm", wake_pulse, 1);
    tick();
    do_wait(48'h5_0000, 1'b0, "R7 pending after wake");

    do_arm(48'h500);
    do_wake();
    chk(wake_pulse == 0, "R10 wake_in while idle no pulse", wake_pulse, 0);
    do_wait(48'h4_0000, 1'b0, "R4 wake between arm and wait");
    do_wait(48'h4_0000, 1'b1, "R4 next wait halts");
    do_wake();
    chk(wake_pulse == 1, "R10 wake_in wakes", wake_pulse, 1);
    tick();
    chk(halt_req == 0, "R6 halt dropped after wake_in", halt_req, 0);
    do_wait(48'h4_0000, 1'b0, "R7 wake_in left pending");

    wait_valid = 1; wait_paddr = 48'h4_0000; wake_in = 1;
    exp_q.push_back(1'b0); req_q.push_back("R4 wake_in same cycle as wait");
    tick();
    chk(halt_req == 0, "R4 no halt same-cycle wake", halt_req, 0);
    do_wait(48'h4_0000, 1'b1, "R4 halts after same-cycle consume");
    do_wake();
    tick(); tick();

    chk(exp_q.size() == 0, "R3 all wait results seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule